// File: doc/BRIEF.md
# Gated Supervisor Timer Compare Unit

This block produces the supervisor timer-pending bit and the virtual-supervisor timer-pending bit for one hart. Two compare registers are held inside the block. The supervisor lane compares its register against the shared time count. The virtual-supervisor lane compares its register against the time count plus a hypervisor time offset. Each lane is driven by hardware only while its enable conditions hold. The supervisor lane needs the machine-level enable bit. The virtual lane needs the hypervisor strap, the machine-level enable bit and the hypervisor-level enable bit.

While a lane is not hardware-driven, software owns its pending bit. The block then shows a shadow bit that software writes through the interrupt-pending write port. The block also drives a two-bit write mask, which tells the CSR file which pending bits software may currently write.

The two enable bits can be written in two ways. A full-width write takes the enable from the top bit of the data word. An upper-half alias write, as a 32-bit hart would use, takes it from the top bit of the lower half of the data word. Every comparison is registered. A new time value, compare value, offset or enable therefore reaches the pending outputs at the next clock edge.

Top module: `sstc_timer_unit`

## Requirements
- R1: After reset, stip_o and vstip_o are 0, mip_wmask_o is 2'b11, and both enable bits are 0.
- R2: While the supervisor lane is active, stip_o equals (stcmp <= time_i) as an unsigned compare. The value is taken from the inputs and registers as they stood before the clock edge that updates the output.
- R3: While the virtual lane is active, vstip_o equals (vstcmp <= (time_i + htdelta_i) mod 2^TW) as an unsigned compare. It has the same one-edge latency as R2.
- R4: mip_wmask_o bit 0 (STIP) is 0 exactly when the supervisor lane is active. Bit 1 (VSTIP) is 0 exactly when the virtual lane is active. A software write to a bit whose mask bit is 0 has no effect on that pending output.
- R5: While a lane is inactive, its pending output shows a shadow bit. The shadow bit is written by mip_sw_we_i with mip_sw_wdata_i, where bit 0 goes to STIP and bit 1 to VSTIP. The written value appears two edges after the write cycle.
- R6: Clearing the machine-level enable returns both lanes to their shadow bits. Clearing the hypervisor-level enable returns only the virtual lane, and the supervisor lane stays hardware-driven.
- R7: A full-width enable write takes the enable from bit EW-1 of env_wdata_i. An upper-half alias write takes it from bit EW/2-1. If both write strobes for the same enable are set in one cycle, the full-width write wins.
- R8: Setting an enable bit hands the lane to the comparator. The pending output shows the compare result at the second edge after the write, even when the shadow bit differs.
- R9: A compare register loads cmp_wdata_i when its write strobe is set, and it resets to 0.
- R10: With hyp_present_i at 0, the virtual lane is inactive whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | TW | Shared time count |
| htdelta_i | input | TW | Hypervisor time offset added for the virtual lane |
| hyp_present_i | input | 1 | Hypervisor extension strap |
| cmp_wdata_i | input | TW | Write data for the compare registers |
| scmp_we_i | input | 1 | Write strobe for the supervisor compare register |
| vscmp_we_i | input | 1 | Write strobe for the virtual compare register |
| env_wdata_i | input | EW | Write data for the enable registers |
| menv_we_i | input | 1 | Full-width write of the machine-level enable |
| menv_hi_we_i | input | 1 | Upper-half alias write of the machine-level enable |
| henv_we_i | input | 1 | Full-width write of the hypervisor-level enable |
| henv_hi_we_i | input | 1 | Upper-half alias write of the hypervisor-level enable |
| mip_sw_we_i | input | 1 | Software write of the pending bits |
| mip_sw_wdata_i | input | 2 | Software pending data, bit 0 STIP, bit 1 VSTIP |
| stip_o | output | 1 | Supervisor timer pending |
| vstip_o | output | 1 | Virtual-supervisor timer pending |
| mip_wmask_o | output | 2 | Software write mask, bit 0 STIP, bit 1 VSTIP |

## Verification
The bench builds the block with TW=4 and EW=8. At that size the supervisor compare can be swept over all 256 pairs of compare value and time. The virtual compare can be swept over all 4096 triples of compare value, time and offset, which covers every wrap of the offset sum. With EW=8, the full-width enable bit sits at bit 7 and the alias bit at bit 3, so the bench can drive each write path on its own and also drive both in the same cycle.

// File: rtl/sstc_pkg.sv
package sstc_pkg;
  // lane indices; also index the enable registers (0: machine, 1: hypervisor)
  localparam int LANE_S  = 0;
  localparam int LANE_VS = 1;
  localparam int NLANE   = 2;

  // next value of an enable register, full-width write has priority
  function automatic logic stce_next(input logic full_we, input logic hi_we,
                                     input logic full_bit, input logic hi_bit,
                                     input logic cur);
    if (full_we)    return full_bit;
    else if (hi_we) return hi_bit;
    else            return cur;
  endfunction
endpackage

// File: rtl/sstc_stce_bit.sv
module sstc_stce_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic full_we_i,
  input  logic hi_we_i,
  input  logic full_bit_i,
  input  logic hi_bit_i,
  output logic en_o
);
  import sstc_pkg::*;

  logic en_q, en_d, en_ce;

  always_comb begin
    en_ce = full_we_i | hi_we_i;
    en_d  = stce_next(full_we_i, hi_we_i, full_bit_i, hi_bit_i, en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/sstc_cmp_lane.sv
module sstc_cmp_lane #(
  parameter int TW     = 64,
  parameter bit HAS_HW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we_i,
  input  logic [TW-1:0] cmp_wdata_i,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] offset_i,
  input  logic          active_i,
  input  logic          sw_we_i,
  input  logic          sw_bit_i,
  output logic          pend_o,
  output logic [TW-1:0] cmp_o
);
  logic [TW-1:0] cmp_q;
  logic          shadow_q, shadow_d, shadow_ce;
  logic          pend_q, pend_d;

  // compare register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_q <= '0;
    else if (cmp_we_i) cmp_q <= cmp_wdata_i;
  end

  // software shadow: writable only while the lane is not hardware-driven
  always_comb begin
    shadow_ce = sw_we_i & ~active_i;
    shadow_d  = sw_bit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= 1'b0;
    else if (shadow_ce) shadow_q <= shadow_d;
  end

  generate
    if (HAS_HW) begin : g_hw
      logic [TW-1:0] ref_val;
      logic          hit;
      always_comb begin
        ref_val = time_i + offset_i;       // wraps modulo 2^TW
        hit     = (cmp_q <= ref_val);      // unsigned
        pend_d  = active_i ? hit : shadow_q;
      end
    end else begin : g_sw
      logic [TW-1:0] unused_lane;
      assign unused_lane = time_i ^ offset_i;
      always_comb pend_d = shadow_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/sstc_timer_unit.sv
module sstc_timer_unit #(
  parameter int TW       = 64,
  parameter int EW       = 64,
  parameter bit HAS_SSTC = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] htdelta_i,
  input  logic          hyp_present_i,
  input  logic [TW-1:0] cmp_wdata_i,
  input  logic          scmp_we_i,
  input  logic          vscmp_we_i,
  input  logic [EW-1:0] env_wdata_i,
  input  logic          menv_we_i,
  input  logic          menv_hi_we_i,
  input  logic          henv_we_i,
  input  logic          henv_hi_we_i,
  input  logic          mip_sw_we_i,
  input  logic [1:0]    mip_sw_wdata_i,
  output logic          stip_o,
  output logic          vstip_o,
  output logic [1:0]    mip_wmask_o
);
  import sstc_pkg::*;

  localparam int FULL_BIT = EW - 1;
  localparam int HI_BIT   = EW / 2 - 1;

  logic [NLANE-1:0] en_full_we, en_hi_we, en_q;
  logic [NLANE-1:0] lane_act, lane_cmp_we, lane_pend;
  logic [TW-1:0]    lane_ofs [NLANE];
  logic [TW-1:0]    lane_cmp [NLANE];
  logic             m_en, h_en, s_act, vs_act;
  logic [TW-1:0]    scmp, vscmp;
  logic [EW-1:0]    unused_env;

  assign unused_env = env_wdata_i;

  always_comb begin
    en_full_we[LANE_S]  = menv_we_i;
    en_hi_we[LANE_S]    = menv_hi_we_i;
    en_full_we[LANE_VS] = henv_we_i;
    en_hi_we[LANE_VS]   = henv_hi_we_i;
  end

  generate
    for (genvar e = 0; e < NLANE; e++) begin : g_en
      sstc_stce_bit u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_we_i (en_full_we[e]),
        .hi_we_i   (en_hi_we[e]),
        .full_bit_i(env_wdata_i[FULL_BIT]),
        .hi_bit_i  (env_wdata_i[HI_BIT]),
        .en_o      (en_q[e])
      );
    end
  endgenerate

  always_comb begin
    m_en   = en_q[LANE_S];
    h_en   = en_q[LANE_VS];
    s_act  = HAS_SSTC & m_en;
    vs_act = HAS_SSTC & hyp_present_i & m_en & h_en;
    lane_act[LANE_S]     = s_act;
    lane_act[LANE_VS]    = vs_act;
    lane_cmp_we[LANE_S]  = scmp_we_i;
    lane_cmp_we[LANE_VS] = vscmp_we_i;
    lane_ofs[LANE_S]     = '0;
    lane_ofs[LANE_VS]    = htdelta_i;
  end

  generate
    for (genvar l = 0; l < NLANE; l++) begin : g_lane
      sstc_cmp_lane #(.TW(TW), .HAS_HW(HAS_SSTC)) u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_we_i   (lane_cmp_we[l]),
        .cmp_wdata_i(cmp_wdata_i),
        .time_i     (time_i),
        .offset_i   (lane_ofs[l]),
        .active_i   (lane_act[l]),
        .sw_we_i    (mip_sw_we_i),
        .sw_bit_i   (mip_sw_wdata_i[l]),
        .pend_o     (lane_pend[l]),
        .cmp_o      (lane_cmp[l])
      );
    end
  endgenerate

  assign scmp        = lane_cmp[LANE_S];
  assign vscmp       = lane_cmp[LANE_VS];
  assign stip_o      = lane_pend[LANE_S];
  assign vstip_o     = lane_pend[LANE_VS];
  assign mip_wmask_o = ~lane_act;
endmodule

// File: rtl/sstc_timer_unit_chk.sv
module sstc_timer_unit_chk #(
  parameter int TW = 64,
  parameter int EW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_act,
  input logic          vs_act,
  input logic          m_en,
  input logic          h_en,
  input logic          hyp_present_i,
  input logic [TW-1:0] scmp,
  input logic [TW-1:0] vscmp,
  input logic [TW-1:0] time_i,
  input logic [TW-1:0] htdelta_i,
  input logic          stip_o,
  input logic          vstip_o,
  input logic [1:0]    mip_wmask_o,
  input logic          menv_we_i,
  input logic          menv_hi_we_i,
  input logic [EW-1:0] env_wdata_i
);
  // R2
  stip_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_act |=> (stip_o == $past(scmp <= time_i)));

  // R3
  vstip_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs_act |=> (vstip_o == $past(vscmp <= TW'(time_i + htdelta_i))));

  // R4
  stip_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_en |-> !mip_wmask_o[0]);

  // R10
  vstip_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hyp_present_i || !h_en || !m_en) |-> mip_wmask_o[1]);

  // R7
  alias_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (menv_hi_we_i && !menv_we_i) |=> (m_en == $past(env_wdata_i[EW/2-1])));
endmodule

bind sstc_timer_unit sstc_timer_unit_chk #(.TW(TW), .EW(EW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_act        (s_act),
  .vs_act       (vs_act),
  .m_en         (m_en),
  .h_en         (h_en),
  .hyp_present_i(hyp_present_i),
  .scmp         (scmp),
  .vscmp        (vscmp),
  .time_i       (time_i),
  .htdelta_i    (htdelta_i),
  .stip_o       (stip_o),
  .vstip_o      (vstip_o),
  .mip_wmask_o  (mip_wmask_o),
  .menv_we_i    (menv_we_i),
  .menv_hi_we_i (menv_hi_we_i),
  .env_wdata_i  (env_wdata_i)
);

// File: tb/sstc_timer_unit_test.sv
module sstc_timer_unit_test;
  localparam int TW = 4;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [TW-1:0] time_i, htdelta_i, cmp_wdata_i;
  logic          hyp_present_i, scmp_we_i, vscmp_we_i;
  logic [EW-1:0] env_wdata_i;
  logic          menv_we_i, menv_hi_we_i, henv_we_i, henv_hi_we_i;
  logic          mip_sw_we_i;
  logic [1:0]    mip_sw_wdata_i;
  logic          stip_o, vstip_o;
  logic [1:0]    mip_wmask_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sstc_timer_unit #(.TW(TW), .EW(EW), .HAS_SSTC(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .htdelta_i(htdelta_i),
    .hyp_present_i(hyp_present_i), .cmp_wdata_i(cmp_wdata_i),
    .scmp_we_i(scmp_we_i), .vscmp_we_i(vscmp_we_i), .env_wdata_i(env_wdata_i),
    .menv_we_i(menv_we_i), .menv_hi_we_i(menv_hi_we_i),
    .henv_we_i(henv_we_i), .henv_hi_we_i(henv_hi_we_i),
    .mip_sw_we_i(mip_sw_we_i), .mip_sw_wdata_i(mip_sw_wdata_i),
    .stip_o(stip_o), .vstip_o(vstip_o), .mip_wmask_o(mip_wmask_o)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_cmp(input bit vs, input int v);
    cmp_wdata_i = TW'(v);
    scmp_we_i   = !vs;
    vscmp_we_i  = vs;
    step();
    scmp_we_i  = 1'b0;
    vscmp_we_i = 1'b0;
  endtask

  // which: 0 machine, 1 hypervisor; hi selects the upper-half alias (bit 3)
  task automatic wr_env(input bit which, input bit hi, input bit val);
    env_wdata_i = '0;
    if (hi) env_wdata_i[EW/2-1] = val;
    else    env_wdata_i[EW-1]   = val;
    menv_we_i    = !which && !hi;
    menv_hi_we_i = !which && hi;
    henv_we_i    = which && !hi;
    henv_hi_we_i = which && hi;
    step();
    {menv_we_i, menv_hi_we_i, henv_we_i, henv_hi_we_i} = '0;
  endtask

  task automatic sw_mip(input int v);
    mip_sw_we_i    = 1'b1;
    mip_sw_wdata_i = 2'(v);
    step();
    mip_sw_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    time_i = '0; htdelta_i = '0; cmp_wdata_i = '0; hyp_present_i = 1'b0;
    scmp_we_i = 1'b0; vscmp_we_i = 1'b0; env_wdata_i = '0;
    {menv_we_i, menv_hi_we_i, henv_we_i, henv_hi_we_i} = '0;
    mip_sw_we_i = 1'b0; mip_sw_wdata_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check("R1 stip", stip_o, 0);
    check("R1 vstip", vstip_o, 0);
    check("R1 wmask", mip_wmask_o, 3);

    // R5 shadow bits written while both lanes are inactive
    time_i = 4'd3;
    wr_cmp(0, 15);
    sw_mip(3);
    step();
    check("R5 stip shadow", stip_o, 1);
    check("R5 vstip shadow", vstip_o, 1);

    // R7 full write of machine enable, R4 mask, R8 comparator takes over
    wr_env(0, 0, 1);
    check("R4 wmask stip locked", mip_wmask_o, 2);
    step();
    check("R8 stip from compare", stip_o, 0);

    // R4 software write to a masked bit is ignored
    sw_mip(3);
    step();
    check("R4 masked stip write", stip_o, 0);
    check("R5 vstip still shadow", vstip_o, 1);

    // R2 / R9 exhaustive supervisor compare
    for (int c = 0; c < 16; c++) begin
      wr_cmp(0, c);
      for (int t = 0; t < 16; t++) begin
        time_i = 4'(t);
        step();
        check("R2 stip sweep", stip_o, (c <= t) ? 1 : 0);
      end
    end

    // R10 hypervisor absent: virtual lane stays software-owned
    sw_mip(0);
    step();
    wr_env(1, 0, 1);
    step();
    check("R10 wmask", mip_wmask_o, 2);
    check("R10 vstip shadow", vstip_o, 0);

    // R7 alias write of hypervisor enable
    wr_env(1, 1, 0);
    hyp_present_i = 1'b1;
    step();
    check("R7 alias clear", mip_wmask_o, 2);
    wr_env(1, 1, 1);
    check("R7 alias set", mip_wmask_o, 0);
    step();
    check("R8 vstip from compare", vstip_o, 1);

    // R3 exhaustive virtual compare with offset wrap
    for (int c = 0; c < 16; c++) begin
      wr_cmp(1, c);
      for (int t = 0; t < 16; t++) begin
        for (int d = 0; d < 16; d++) begin
          time_i    = 4'(t);
          htdelta_i = 4'(d);
          step();
          check("R3 vstip sweep", vstip_o, (c <= ((t + d) % 16)) ? 1 : 0);
        end
      end
    end

    // R7 both strobes in one cycle: full write wins
    env_wdata_i = '0;
    env_wdata_i[EW-1] = 1'b1;
    menv_we_i = 1'b1;
    menv_hi_we_i = 1'b1;
    step();
    {menv_we_i, menv_hi_we_i} = '0;
    check("R7 full wins", mip_wmask_o, 0);

    // R6 clear hypervisor enable: only the virtual lane reverts
    time_i = 4'd0;
    htdelta_i = 4'd0;
    wr_cmp(1, 0);
    wr_cmp(0, 15);
    wr_env(1, 0, 0);
    step();
    check("R6 wmask after henv clear", mip_wmask_o, 2);
    check("R6 vstip shadow", vstip_o, 0);
    check("R6 stip still compare", stip_o, 0);

    // R6 clear machine enable through the alias: both revert
    wr_env(0, 1, 0);
    step();
    check("R6 wmask after menv clear", mip_wmask_o, 3);
    check("R6 stip shadow", stip_o, 1);
    check("R6 vstip shadow", vstip_o, 0);

    // R6 hypervisor enable alone does not drive the virtual lane
    wr_env(1, 0, 1);
    step();
    check("R6 wmask henv only", mip_wmask_o, 3);
    check("R6 vstip henv only", vstip_o, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule